// File: doc/BRIEF.md
# Five-Port Mesh Packet Switch with Selectable Forwarding

This block is a single switch for a three-by-three mesh that joins nine cores. It has five ports: one for the attached core and four for the neighbouring switches. Each link carries one 32-bit flit per cycle under a valid/ready handshake, with a tail flag on the last flit. A packet is always sixteen flits long: a header flit followed by fifteen payload flits. The header holds the destination coordinates. The switch steers each packet using dimension-ordered routing, correcting X before Y, and delivers it to the core port once both coordinates match its own.

Every input port has a buffer that holds one whole packet. When the buffer is full, the input drops its ready signal, so a packet is never discarded. A single mode input chooses between two forwarding modes:
- Store-and-forward: a packet is offered to its output only once its tail flit is buffered.
- Cut-through: the header is offered in the cycle after it arrives.

Each output has its own round-robin arbiter. The arbiter keeps its grant for the whole packet, so packets never interleave on a link.

Top module: `mesh_router`

## Requirements
- R1: Header bits [1:0] carry destination X and bits [3:2] carry destination Y. With the switch at (MY_X, MY_Y), a larger X leaves on port 3 (east) and a smaller X on port 4 (west). Otherwise a larger Y leaves on port 1 (north) and a smaller Y on port 2 (south). Otherwise the packet leaves on port 0 (local). Port p uses data lane bits [32p+31:32p].
- R2: With cut_mode=1 and an idle output, a header accepted at clock edge E is presented valid on its output in the cycle that follows edge E.
- R3: With cut_mode=0, no flit of a packet is presented before its tail has been accepted. A packet whose tail is accepted at edge T, and whose output is idle, presents its header in the cycle that follows edge T.
- R4: The sixteen flits of a packet appear on an output back to back, in order, with the tail flag set only on the sixteenth. No flit of another packet comes between them.
- R5: When several inputs compete for one output, the grant goes to the first requester at or after a pointer, searching in rising port order. The pointer then moves to one past the winner. The pointer starts at port 0.
- R6: Once an input buffer holds 16 flits, that input's ready is low. Every accepted packet is eventually delivered.
- R7: While an output is valid and not ready, it stays valid with unchanged data in the next cycle.
- R8: During and right after reset, every out_valid is low and every in_ready is high.
- R9: An input feeds at most one output at a time, and packets to different outputs move in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cut_mode | input | 1 | 1 selects cut-through, 0 selects store-and-forward |
| in_valid | input | 5 | Flit valid per input port |
| in_data | input | 160 | Flit data, 32 bits per input port |
| in_tail | input | 5 | Last-flit flag per input port |
| in_ready | output | 5 | Input buffer can accept a flit |
| out_valid | output | 5 | Flit valid per output port |
| out_data | output | 160 | Flit data, 32 bits per output port |
| out_tail | output | 5 | Last-flit flag per output port |
| out_ready | input | 5 | Downstream can accept a flit |

## Verification
The bench builds the switch with its coordinates at (1,1), the centre of the grid, so that all five outputs can be reached from the nine destinations. It keeps the buffer depth at 16 flits, exactly one packet. That depth lets a stalled output fill an input buffer and drop in_ready after a single packet. It also means one store-and-forward packet fills the buffer before the header is offered, which makes the tail-to-header timing directly measurable.

// File: rtl/router_pkg.sv
package router_pkg;

    localparam int NPORTS = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    // Dimension-ordered choice: X first, then Y, then eject.
    function automatic port_e xy_route(input logic [1:0] dst_x, input logic [1:0] dst_y,
                                       input logic [1:0] my_x,  input logic [1:0] my_y);
        if (dst_x > my_x) return P_EAST;
        if (dst_x < my_x) return P_WEST;
        if (dst_y > my_y) return P_NORTH;
        if (dst_y < my_y) return P_SOUTH;
        return P_LOCAL;
    endfunction

endpackage

// File: rtl/router_input_unit.sv
module router_input_unit
    import router_pkg::*;
#(
    parameter int         FLIT_W = 32,
    parameter int         DEPTH  = 16,
    parameter logic [1:0] MY_X   = 2'd1,
    parameter logic [1:0] MY_Y   = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cut_mode,
    input  logic              push_valid,
    input  logic [FLIT_W-1:0] push_data,
    input  logic              push_tail,
    output logic              push_ready,
    output logic [FLIT_W-1:0] head_data,
    output logic              head_tail,
    output logic              head_ok,
    output logic [NPORTS-1:0] req,
    input  logic              pop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic [CW-1:0] tails;
        logic          in_pkt;
    } iu_s;

    iu_s st_q, st_d;
    logic [FLIT_W:0] mem_q [DEPTH];
    logic            push;
    logic            eligible;
    port_e           dir;

    assign push_ready = (st_q.cnt != CW'(DEPTH));
    assign push       = push_valid && push_ready;
    assign head_ok    = (st_q.cnt != '0);
    assign head_data  = mem_q[st_q.rd][FLIT_W-1:0];
    assign head_tail  = mem_q[st_q.rd][FLIT_W];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt   = st_q.cnt + CW'(push) - CW'(pop);
        st_d.tails = st_q.tails + CW'(push && push_tail) - CW'(pop && head_tail);
        if (pop) st_d.in_pkt = !head_tail;

        dir      = xy_route(head_data[1:0], head_data[3:2], MY_X, MY_Y);
        eligible = head_ok && !st_q.in_pkt && (cut_mode || st_q.tails != '0);
        req      = '0;
        if (eligible) req[dir] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= {push_tail, push_data};
    end
endmodule

// File: rtl/router_rr_arbiter.sv
module router_rr_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         xfer,
    input  logic         xfer_tail,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } arb_s;

    arb_s          st_q, st_d;
    logic          found;
    logic [IW-1:0] pick;
    int            idx;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(st_q.ptr) + i) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end

        gnt = '0;
        if (st_q.locked)  gnt[st_q.owner] = 1'b1;
        else if (found)   gnt[pick]       = 1'b1;

        if (!st_q.locked && found) begin
            st_d.locked = 1'b1;
            st_d.owner  = pick;
            st_d.ptr    = (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
        end
        if (xfer && xfer_tail) st_d.locked = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import router_pkg::*;
#(
    parameter int         FLIT_W    = 32,
    parameter int         BUF_DEPTH = 16,
    parameter logic [1:0] MY_X      = 2'd1,
    parameter logic [1:0] MY_Y      = 2'd1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cut_mode,
    input  logic [NPORTS-1:0]        in_valid,
    input  logic [NPORTS*FLIT_W-1:0] in_data,
    input  logic [NPORTS-1:0]        in_tail,
    output logic [NPORTS-1:0]        in_ready,
    output logic [NPORTS-1:0]        out_valid,
    output logic [NPORTS*FLIT_W-1:0] out_data,
    output logic [NPORTS-1:0]        out_tail,
    input  logic [NPORTS-1:0]        out_ready
);
    logic [NPORTS-1:0]             ok_v, ht_v, pop_v;
    logic [NPORTS-1:0][FLIT_W-1:0] hd_v;
    logic [NPORTS-1:0][NPORTS-1:0] req_by_in;
    logic [NPORTS-1:0][NPORTS-1:0] req_by_out;
    logic [NPORTS-1:0][NPORTS-1:0] gnt;
    logic [NPORTS-1:0][FLIT_W-1:0] od_v;

    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        router_input_unit #(
            .FLIT_W(FLIT_W), .DEPTH(BUF_DEPTH), .MY_X(MY_X), .MY_Y(MY_Y)
        ) u_iu (
            .clk       (clk),
            .rst_n     (rst_n),
            .cut_mode  (cut_mode),
            .push_valid(in_valid[i]),
            .push_data (in_data[i*FLIT_W +: FLIT_W]),
            .push_tail (in_tail[i]),
            .push_ready(in_ready[i]),
            .head_data (hd_v[i]),
            .head_tail (ht_v[i]),
            .head_ok   (ok_v[i]),
            .req       (req_by_in[i]),
            .pop       (pop_v[i])
        );
    end

    for (genvar o = 0; o < NPORTS; o++) begin : g_out
        router_rr_arbiter #(.N(NPORTS)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_by_out[o]),
            .xfer     (out_valid[o] && out_ready[o]),
            .xfer_tail(out_tail[o]),
            .gnt      (gnt[o])
        );
        assign out_data[o*FLIT_W +: FLIT_W] = od_v[o];
    end

    always_comb begin
        for (int o = 0; o < NPORTS; o++) begin
            for (int i = 0; i < NPORTS; i++) req_by_out[o][i] = req_by_in[i][o];
        end
        for (int o = 0; o < NPORTS; o++) begin
            out_valid[o] = 1'b0;
            out_tail[o]  = 1'b0;
            od_v[o]      = '0;
            for (int i = 0; i < NPORTS; i++) begin
                if (gnt[o][i]) begin
                    out_valid[o] = out_valid[o] | ok_v[i];
                    out_tail[o]  = out_tail[o]  | ht_v[i];
                    od_v[o]      = od_v[o]      | hd_v[i];
                end
            end
        end
        for (int i = 0; i < NPORTS; i++) begin
            pop_v[i] = 1'b0;
            for (int o = 0; o < NPORTS; o++) begin
                if (gnt[o][i] && out_ready[o] && ok_v[i]) pop_v[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
    import router_pkg::*;
#(
    parameter int         FLIT_W = 32,
    parameter logic [1:0] MY_X   = 2'd1,
    parameter logic [1:0] MY_Y   = 2'd1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NPORTS-1:0]             out_valid,
    input logic [NPORTS*FLIT_W-1:0]      out_data,
    input logic [NPORTS-1:0]             out_tail,
    input logic [NPORTS-1:0]             out_ready,
    input logic [NPORTS-1:0][NPORTS-1:0] gnt
);
    logic [NPORTS-1:0] mid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mid_q <= '0;
        else begin
            for (int o = 0; o < NPORTS; o++) begin
                if (out_valid[o] && out_ready[o]) mid_q[o] <= !out_tail[o];
            end
        end
    end

    for (genvar o = 0; o < NPORTS; o++) begin : g_o
        AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W])); // R7
        AST_HDR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !mid_q[o] |-> int'(xy_route(out_data[o*FLIT_W +: 2],
                out_data[o*FLIT_W+2 +: 2], MY_X, MY_Y)) == o); // R1
        AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_ready[o] && !out_tail[o] |=> $stable(gnt[o])); // R4
    end

    for (genvar i = 0; i < NPORTS; i++) begin : g_i
        logic [NPORTS-1:0] col;
        always_comb begin
            for (int o = 0; o < NPORTS; o++) col[o] = gnt[o][i];
        end
        AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col)); // R9
    end
endmodule

bind mesh_router mesh_router_chk #(.FLIT_W(FLIT_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_tail (out_tail),
    .out_ready(out_ready),
    .gnt      (gnt)
);

// File: tb/tb_mesh_router.sv
`timescale 1ns/1ps
module tb_mesh_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cut_mode = 1'b1;
    logic [4:0]   in_valid = '0, in_tail = '0, in_ready;
    logic [159:0] in_data = '0;
    logic [4:0]   out_valid, out_tail;
    logic [4:0]   out_ready = '1;
    logic [159:0] out_data;

    mesh_router dut (.*);

    always #2 clk = ~clk;

    int nvec = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;
    int exp_q[5][$];
    int order_q[$];
    int hdr_in_cyc[5], tail_in_cyc[5], hdr_out_cyc[5];
    int delivered = 0, sent = 0;
    bit busy[5];
    int cur_tag[5], kk[5];
    bit stall_prev[5];
    logic [31:0] stall_data[5];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int model_route(input int dx, input int dy);
        if (dx > 1) return 3;
        if (dx < 1) return 4;
        if (dy > 1) return 1;
        if (dy < 1) return 2;
        return 0;
    endfunction

    // Driver: queues the expected packet, then feeds its 16 flits.
    task automatic send_pkt(input int p, input int dx, input int dy, input int tag);
        exp_q[model_route(dx, dy)].push_back(tag);
        sent++;
        for (int k = 0; k < 16;) begin
            @(negedge clk);
            in_valid[p] = 1'b1;
            in_tail[p]  = (k == 15);
            in_data[p*32 +: 32] = (k == 0) ? {tag[15:0], 12'h0, dy[1:0], dx[1:0]}
                                           : {tag[15:0], 16'(k)};
            if (in_ready[p]) begin
                if (k == 0)  hdr_in_cyc[p]  = cyc + 1;
                if (k == 15) tail_in_cyc[p] = cyc + 1;
                k++;
            end
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
        in_tail[p]  = 1'b0;
    endtask

    function automatic bit pending();
        for (int o = 0; o < 5; o++) if (exp_q[o].size() != 0 || busy[o]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic drain();
        while (pending()) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                for (int o = 0; o < 5; o++) begin
                    logic [31:0] d;
                    d = out_data[o*32 +: 32];
                    if (stall_prev[o])
                        chk(out_valid[o] && d == stall_data[o], "R7 stalled output held", d, stall_data[o]);
                    if (out_valid[o] && out_ready[o]) begin
                        if (!busy[o]) begin
                            int hit;
                            hit = -1;
                            foreach (exp_q[o][j]) if (hit < 0 && exp_q[o][j] == int'(d[31:16])) hit = j;
                            chk(hit >= 0, "R1 header on routed port", d, 32'(o));
                            if (hit >= 0) exp_q[o].delete(hit);
                            chk(!out_tail[o], "R4 header not tail", 32'(out_tail[o]), 0);
                            cur_tag[o] = int'(d[31:16]);
                            kk[o] = 1;
                            busy[o] = 1'b1;
                            hdr_out_cyc[o] = cyc;
                            if (o == 0) order_q.push_back(cur_tag[o]);
                        end else begin
                            chk(d == {cur_tag[o][15:0], 16'(kk[o])} && out_tail[o] == (kk[o] == 15),
                                "R4 contiguous payload", d, {cur_tag[o][15:0], 16'(kk[o])});
                            kk[o]++;
                            if (kk[o] == 16) begin
                                busy[o] = 1'b0;
                                delivered++;
                            end
                        end
                    end
                    stall_prev[o] = out_valid[o] && !out_ready[o];
                    stall_data[o] = d;
                end
            end
        end
    end

    initial begin
        #(4 * 60000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 5'h0, "R8 out_valid in reset", 32'(out_valid), 0);
        chk(in_ready == 5'h1f, "R8 in_ready in reset", 32'(in_ready), 32'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 5'h0, "R8 out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 5'h1f, "R8 in_ready after reset", 32'(in_ready), 32'h1f);

        // R2: cut-through latency, local -> east
        cut_mode = 1'b1;
        send_pkt(0, 2, 1, 16'h0101);
        drain();
        chk(hdr_out_cyc[3] == hdr_in_cyc[0], "R2 cut-through header cycle",
            32'(hdr_out_cyc[3]), 32'(hdr_in_cyc[0]));

        // R3: store-and-forward, west -> local
        cut_mode = 1'b0;
        send_pkt(4, 1, 1, 16'h0202);
        drain();
        chk(hdr_out_cyc[0] == tail_in_cyc[4], "R3 store-and-forward header cycle",
            32'(hdr_out_cyc[0]), 32'(tail_in_cyc[4]));
        chk(hdr_out_cyc[0] > hdr_in_cyc[4] + 14, "R3 header waits for whole packet",
            32'(hdr_out_cyc[0]), 32'(hdr_in_cyc[4] + 15));

        // R9: two inputs to two outputs concurrently
        cut_mode = 1'b1;
        fork
            send_pkt(4, 2, 1, 16'h0303);
            send_pkt(3, 0, 1, 16'h0404);
        join
        drain();
        chk(hdr_out_cyc[3] == hdr_in_cyc[4], "R9 parallel west->east",
            32'(hdr_out_cyc[3]), 32'(hdr_in_cyc[4]));
        chk(hdr_out_cyc[4] == hdr_in_cyc[3], "R9 parallel east->west",
            32'(hdr_out_cyc[4]), 32'(hdr_in_cyc[3]));

        // R5: three inputs contend for local, pointer at 0
        order_q.delete();
        out_ready[0] = 1'b0;
        fork
            send_pkt(1, 1, 1, 16'h0A01);
            send_pkt(2, 1, 1, 16'h0A02);
            send_pkt(4, 1, 1, 16'h0A04);
        join
        repeat (4) @(negedge clk);
        out_ready[0] = 1'b1;
        drain();
        chk(order_q.size() == 3, "R5 grant count", 32'(order_q.size()), 3);
        if (order_q.size() == 3) begin
            chk(order_q[0] == 'h0A01, "R5 first grant", 32'(order_q[0]), 32'h0A01);
            chk(order_q[1] == 'h0A02, "R5 second grant", 32'(order_q[1]), 32'h0A02);
            chk(order_q[2] == 'h0A04, "R5 third grant", 32'(order_q[2]), 32'h0A04);
        end

        // R1: every destination from the local port
        for (int dx = 0; dx < 3; dx++)
            for (int dy = 0; dy < 3; dy++)
                send_pkt(0, dx, dy, 'h1000 + dx * 16 + dy);
        drain();

        // R6: backpressure fills the buffer, nothing lost
        cut_mode = 1'b0;
        out_ready[3] = 1'b0;
        fork
            begin
                send_pkt(0, 2, 0, 16'h2001);
                send_pkt(0, 2, 2, 16'h2002);
            end
        join_none
        repeat (40) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R6 ready low with full buffer", 32'(in_ready[0]), 0);
        chk(out_valid[3] == 1'b1, "R7 output waits while stalled", 32'(out_valid[3]), 1);
        out_ready[3] = 1'b1;
        wait fork;
        drain();
        chk(delivered == sent, "R6 all packets delivered", 32'(delivered), 32'(sent));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule